// File: doc/BRIEF.md
# Shared Backplane Bus Slave Decoder

This block is the slave end of a parallel backplane bus for one compute chip. A single master drives a 16-bit address, a 64-bit write data bus, a strobe and a write/read select. Every chip on every plug-in module sees the same bus. Each chip receives two strap inputs: the slot number of its module and its position on that module. Two chips with the same configuration can therefore still be told apart.

The address holds three fields. A 5-bit slot field selects a module; the all-ones value reaches every module. A 6-bit field has one bit per chip on the module. A 5-bit field picks a local register. A write reaches every chip whose slot matches and whose select bit is set, so one bus cycle can load a single chip, any chosen group of chips, or the whole machine. A read is answered only when the slot field names this module exactly and exactly one select bit is set, and that bit is this chip's. In every other case the chip keeps its output-enable low, so the external tri-state buffer never drives the bus. There are no interrupts. The master learns about results by polling a read-only result register fed by the compute core.

Top module: `bpl_slave_port`

## Requirements
- R1: While reset is low and in the first cycle after it, every configuration register reads zero on `cfg_q` and `bus_doe` is low.
- R2: A strobed write (`bus_we`=1) updates register k (`cfg_q[k*64 +: 64]`) from `bus_din` at that clock edge. This applies when the address is {slot[15:11], select[10:5], reg[4:0]}, slot equals `slot_id`, select bit `chip_idx` is set and reg k < NUM_CFG.
- R3: A write whose select field has several bits set, including this chip's bit, updates the register exactly as a single-chip write does.
- R4: A write whose slot field is 5'h1F updates the register on every module, whatever `slot_id` is.
- R5: A write or read whose slot field matches neither `slot_id` nor 5'h1F, or whose select bit for this chip is clear, changes no register and leaves `bus_doe` low.
- R6: A read (`bus_we`=0) is unicast when the slot field equals `slot_id` and the select field is one-hot on this chip's bit. For a unicast read, `bus_doe` is high, with the register value on `bus_dout`, in exactly the one cycle after the strobe edge.
- R7: A read with more than one select bit set, or with the all-boards slot value, keeps `bus_doe` low.
- R8: A unicast read of a register index that is neither below NUM_CFG nor equal to RESULT_IDX (default 16) returns zero, with `bus_doe` high.
- R9: A unicast read of RESULT_IDX returns `core_result` as sampled at the strobe edge. A write to RESULT_IDX changes no configuration register.
- R10: With `bus_stb` low, no register changes and `bus_doe` stays low, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_id | input | 5 | Strapped slot number of this module |
| chip_idx | input | 3 | Position of this chip on its module (0..5) |
| bus_stb | input | 1 | Bus cycle strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Slot, chip-select and register fields |
| bus_din | input | 64 | Write data from the bus |
| core_result | input | 64 | Result word from the compute core, polled by the master |
| bus_dout | output | 64 | Read data toward the tri-state buffer |
| bus_doe | output | 1 | Enable for the tri-state buffer |
| cfg_q | output | 256 | Configuration registers, concatenated, to the compute core |

## Verification
A write is due on `cfg_q` right after the strobe edge that takes it. A read answer appears on `bus_dout`/`bus_doe` one cycle after its strobe edge and lasts for one cycle only. The bench drives each bus cycle on a falling edge and drops the strobe on the next falling edge. At that same falling edge it samples the result, which lies midway between the capturing edge and the next one. For reads it checks one more falling edge later that the enable has dropped again.

// File: rtl/bpl_pkg.sv
package bpl_pkg;
  localparam int SLOT_W = 5;
  localparam int CSEL_W = 6;
  localparam int REG_W  = 5;
  localparam int ADDR_W = SLOT_W + CSEL_W + REG_W;
  localparam logic [SLOT_W-1:0] ALL_SLOTS = '1;

  function automatic logic [SLOT_W-1:0] slot_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: SLOT_W];
  endfunction

  function automatic logic [CSEL_W-1:0] csel_of(input logic [ADDR_W-1:0] a);
    return a[REG_W +: CSEL_W];
  endfunction

  function automatic logic [REG_W-1:0] reg_of(input logic [ADDR_W-1:0] a);
    return a[REG_W-1:0];
  endfunction

  // true when bit 'pos' of the select field is set (pos beyond field -> false)
  function automatic logic sel_mine(input logic [CSEL_W-1:0] s, input logic [2:0] pos);
    return ((s >> pos) & CSEL_W'(1)) != '0;
  endfunction
endpackage

// File: rtl/bpl_addr_decode.sv
module bpl_addr_decode
  import bpl_pkg::*;
(
  input  logic              bus_stb,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [SLOT_W-1:0] slot_id,
  input  logic [2:0]        chip_idx,
  output logic              wr_hit,
  output logic              rd_hit,
  output logic [REG_W-1:0]  reg_idx
);
  logic [SLOT_W-1:0] slot_f;
  logic [CSEL_W-1:0] csel_f;
  logic slot_exact, slot_any, mine, single;

  always_comb begin
    slot_f     = slot_of(bus_addr);
    csel_f     = csel_of(bus_addr);
    reg_idx    = reg_of(bus_addr);
    slot_exact = (slot_f == slot_id);
    slot_any   = slot_exact || (slot_f == ALL_SLOTS);
    mine       = sel_mine(csel_f, chip_idx);
    single     = ($countones(csel_f) == 1);
    wr_hit     = bus_stb && bus_we && slot_any && mine;
    rd_hit     = bus_stb && !bus_we && slot_exact && mine && single;
  end
endmodule

// File: rtl/bpl_cfg_bank.sv
module bpl_cfg_bank
  import bpl_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int NUM_CFG = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_hit,
  input  logic [REG_W-1:0]          reg_idx,
  input  logic [DATA_W-1:0]         wdata,
  output logic [NUM_CFG*DATA_W-1:0] cfg_flat
);
  logic [NUM_CFG-1:0] we_vec;

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    assign we_vec[g] = wr_hit && (reg_idx == REG_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n)        q <= '0;
      else if (we_vec[g]) q <= wdata;
    end
    assign cfg_flat[g*DATA_W +: DATA_W] = q;

    // R2
    wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_vec[g] |=> q == $past(wdata));
  end

  // R3
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we_vec));
endmodule

// File: rtl/bpl_read_port.sv
module bpl_read_port
  import bpl_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int NUM_CFG    = 4,
  parameter int RESULT_IDX = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_hit,
  input  logic [REG_W-1:0]          reg_idx,
  input  logic [NUM_CFG*DATA_W-1:0] cfg_flat,
  input  logic [DATA_W-1:0]         core_result,
  output logic [DATA_W-1:0]         rd_data,
  output logic                      rd_oe
);
  logic [DATA_W-1:0] sel_word;

  always_comb begin
    sel_word = '0;
    for (int i = 0; i < NUM_CFG; i++)
      if (reg_idx == REG_W'(i)) sel_word = cfg_flat[i*DATA_W +: DATA_W];
    if (reg_idx == REG_W'(RESULT_IDX)) sel_word = core_result;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_oe   <= 1'b0;
    end else begin
      rd_oe   <= rd_hit;
      rd_data <= rd_hit ? sel_word : '0;
    end
  end

  // R9
  result_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit && reg_idx == REG_W'(RESULT_IDX) |=> rd_data == $past(core_result));
endmodule

// File: rtl/bpl_slave_port.sv
module bpl_slave_port
  import bpl_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int NUM_CFG    = 4,
  parameter int RESULT_IDX = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [SLOT_W-1:0]         slot_id,
  input  logic [2:0]                chip_idx,
  input  logic                      bus_stb,
  input  logic                      bus_we,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_din,
  input  logic [DATA_W-1:0]         core_result,
  output logic [DATA_W-1:0]         bus_dout,
  output logic                      bus_doe,
  output logic [NUM_CFG*DATA_W-1:0] cfg_q
);
  logic             wr_hit, rd_hit;
  logic [REG_W-1:0] reg_idx;

  bpl_addr_decode u_dec (
    .bus_stb(bus_stb), .bus_we(bus_we), .bus_addr(bus_addr),
    .slot_id(slot_id), .chip_idx(chip_idx),
    .wr_hit(wr_hit), .rd_hit(rd_hit), .reg_idx(reg_idx)
  );

  bpl_cfg_bank #(.DATA_W(DATA_W), .NUM_CFG(NUM_CFG)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .reg_idx(reg_idx),
    .wdata(bus_din), .cfg_flat(cfg_q)
  );

  bpl_read_port #(.DATA_W(DATA_W), .NUM_CFG(NUM_CFG), .RESULT_IDX(RESULT_IDX)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_hit(rd_hit), .reg_idx(reg_idx),
    .cfg_flat(cfg_q), .core_result(core_result),
    .rd_data(bus_dout), .rd_oe(bus_doe)
  );

  // R10
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_stb && bus_we) |=> $stable(cfg_q));

  // R6
  oe_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> $past(bus_stb && !bus_we));

  // R7
  no_multi_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stb && !bus_we && ($countones(csel_of(bus_addr)) != 1 ||
                           slot_of(bus_addr) == ALL_SLOTS) |=> !bus_doe);

  // R8
  empty_reg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit && reg_idx >= REG_W'(NUM_CFG) && reg_idx != REG_W'(RESULT_IDX)
    |=> bus_doe && bus_dout == '0);

  // R5
  foreign_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stb && !sel_mine(csel_of(bus_addr), chip_idx) |=> !bus_doe);
endmodule

// File: tb/bpl_slave_port_tb.sv
module bpl_slave_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] slot_id = 5'd9;
  logic [2:0] chip_idx = 3'd2;
  logic bus_stb = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [63:0] bus_din = '0, core_result = '0;
  logic [63:0] bus_dout;
  logic bus_doe;
  logic [255:0] cfg_q;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  bpl_slave_port dut_i (
    .clk(clk), .rst_n(rst_n), .slot_id(slot_id), .chip_idx(chip_idx),
    .bus_stb(bus_stb), .bus_we(bus_we), .bus_addr(bus_addr), .bus_din(bus_din),
    .core_result(core_result), .bus_dout(bus_dout), .bus_doe(bus_doe), .cfg_q(cfg_q)
  );

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [63:0] data;
    logic        exp_oe;
    logic [63:0] exp;
  } vec_t;

  // own chip: slot 9, select bit 2 (6'b000100)
  localparam vec_t VECS [13] = '{
    '{1'b1, {5'd9,  6'b000100, 5'd0}, 64'hA0A0, 1'b0, 64'hA0A0}, // R2
    '{1'b0, {5'd9,  6'b000100, 5'd0}, 64'h0,    1'b1, 64'hA0A0}, // R6
    '{1'b1, {5'd9,  6'b111111, 5'd1}, 64'hB1B1, 1'b0, 64'hB1B1}, // R3
    '{1'b1, {5'd9,  6'b001100, 5'd2}, 64'hC2C2, 1'b0, 64'hC2C2}, // R3
    '{1'b1, {5'd31, 6'b000100, 5'd3}, 64'hD3D3, 1'b0, 64'hD3D3}, // R4
    '{1'b1, {5'd7,  6'b000100, 5'd0}, 64'hEEEE, 1'b0, 64'hA0A0}, // R5
    '{1'b1, {5'd9,  6'b111011, 5'd1}, 64'hFFFF, 1'b0, 64'hB1B1}, // R5
    '{1'b0, {5'd9,  6'b000100, 5'd1}, 64'h0,    1'b1, 64'hB1B1}, // R6
    '{1'b0, {5'd9,  6'b001100, 5'd2}, 64'h0,    1'b0, 64'h0},    // R7
    '{1'b0, {5'd31, 6'b000100, 5'd3}, 64'h0,    1'b0, 64'h0},    // R7
    '{1'b0, {5'd9,  6'b000100, 5'd7}, 64'h0,    1'b1, 64'h0},    // R8
    '{1'b0, {5'd9,  6'b000100, 5'd3}, 64'h0,    1'b1, 64'hD3D3}, // R6
    '{1'b0, {5'd9,  6'b000010, 5'd0}, 64'h0,    1'b0, 64'h0}     // R5
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on a falling edge, drop strobe on the next; results are sampled there
  task automatic bus_op(input logic wr, input logic [15:0] a, input logic [63:0] d,
                        input logic stb);
    @(negedge clk);
    bus_stb = stb; bus_we = wr; bus_addr = a; bus_din = d;
    @(negedge clk);
    bus_stb = 1'b0;
  endtask

  function automatic logic [63:0] cfg_word(input int k);
    return cfg_q[k*64 +: 64];
  endfunction

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [255:0] snap;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", cfg_q[63:0] | cfg_q[127:64] | cfg_q[191:128] | cfg_q[255:192], 64'h0);
    chk("R1", {63'h0, bus_doe}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {63'h0, bus_doe}, 64'h0);

    for (int i = 0; i < 13; i++) begin
      bus_op(VECS[i].wr, VECS[i].addr, VECS[i].data, 1'b1);
      if (VECS[i].wr)
        chk($sformatf("R2-5 vec%0d", i), cfg_word(int'(VECS[i].addr[4:0])), VECS[i].exp);
      else begin
        chk($sformatf("R6-8 vec%0d oe", i), {63'h0, bus_doe}, {63'h0, VECS[i].exp_oe});
        if (VECS[i].exp_oe)
          chk($sformatf("R6-8 vec%0d data", i), bus_dout, VECS[i].exp);
      end
    end

    // R6: enable lasts one cycle only
    bus_op(1'b0, {5'd9, 6'b000100, 5'd2}, 64'h0, 1'b1);
    chk("R6", bus_dout, 64'hC2C2);
    @(negedge clk);
    chk("R6", {63'h0, bus_doe}, 64'h0);

    // R9: result register read and write-ignore
    core_result = 64'h1234_5678_9ABC_DEF0;
    bus_op(1'b0, {5'd9, 6'b000100, 5'd16}, 64'h0, 1'b1);
    chk("R9", bus_dout, 64'h1234_5678_9ABC_DEF0);
    snap = cfg_q;
    bus_op(1'b1, {5'd9, 6'b000100, 5'd16}, 64'h5555, 1'b1);
    chk("R9", {192'h0, cfg_q[63:0]} ^ {192'h0, snap[63:0]}, 64'h0);
    chk("R9", (cfg_q ^ snap) != '0 ? 64'h1 : 64'h0, 64'h0);

    // R10: no strobe, nothing happens
    snap = cfg_q;
    bus_op(1'b1, {5'd9, 6'b000100, 5'd0}, 64'h7777, 1'b0);
    chk("R10", (cfg_q ^ snap) != '0 ? 64'h1 : 64'h0, 64'h0);
    bus_op(1'b0, {5'd9, 6'b000100, 5'd0}, 64'h0, 1'b0);
    chk("R10", {63'h0, bus_doe}, 64'h0);

    // R4: broadcast slot reaches a chip in another slot
    slot_id = 5'd3;
    bus_op(1'b1, {5'd31, 6'b000100, 5'd1}, 64'h4242, 1'b1);
    chk("R4", cfg_word(1), 64'h4242);

    // R1: reset in mid-run clears registers
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1", cfg_word(0) | cfg_word(3), 64'h0);
    rst_n = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule